// File: doc/BRIEF.md
# Keyboard Matrix Scan Sequencer

The sequencer steps through a fixed ring of 17 scan lines. It advances one count for each sub-clock strobe. In its own slot, a selected line that can drive is pulled low for one pulse. For the rest of the ring it is left to act as a return input. Two register inputs shape the scan:

- a per-line select mask;
- an input-only mask, marking lines that can never drive.

Two codes set the timing: one gives the pulse width and one gives the spacing between neighbouring pulses. The product of the two sets the length of every slot.

The block does not drive pads. Its outputs are:

- a per-line ownership flag, meaning the line is taken away from normal I/O;
- a per-line drive-low request;
- a 17-bit key-state vector.

A key-state bit is 1 when, at the end of that slot's pulse, some other selected line read low.

Top module: `kscan_seq`

## Requirements
- R1: After the synchronous reset, `key_state`, `drv_low`, `scan_own` and `cycle_done` are all zero and `cur_slot` is 0.
- R2: While `scan_en` is 0, `scan_own` and `drv_low` are all zero whatever the masks hold. While `scan_en` is 1, `scan_own` equals `line_sel`.
- R3: Slot s (0 to 16) belongs to line 16-s, so lines are scanned in descending order 16, 15, ..., 0. After slot 16 the ring wraps to slot 0.
- R4: The low pulse lasts 4, 8, 16 or 32 sub-clock strobes for `width_code` 0, 1, 2 or 3. It starts on the first strobe of the slot.
- R5: A slot lasts 2, 3 or 4 pulse widths for `gap_code` 0, 1 or 2. Code 3 gives the same length as code 2.
- R6: At most one line is driven low at any time. A line is driven only if its `line_sel` bit is 1 and its `in_only` bit is 0.
- R7: The slot of a deselected or input-only line produces no low pulse but keeps the full slot length.
- R8: One ring lasts 17 x pulse x factor strobes. `cycle_done` is high during the final strobe of slot 16.
- R9: On the last strobe of a real pulse, `key_state[s]` is loaded with 1 if any other selected line reads 0 on `ret_in`, and with 0 otherwise. A dummy slot writes 0.
- R10: Whenever `scan_en` is 0 the sequencer is held at the first strobe of slot 0, so re-enabling always restarts there.
- R11: While `tick` is 0, `cur_slot` and `drv_low` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per sub-clock period |
| scan_en | input | 1 | Global scan enable |
| line_sel | input | 17 | Per-line scan select mask |
| in_only | input | 17 | Per-line flag: line cannot drive |
| width_code | input | 2 | Pulse width code |
| gap_code | input | 2 | Non-overlap spacing code |
| ret_in | input | 17 | Sensed line levels (0 = pulled low) |
| scan_own | output | 17 | Line is under scan control |
| drv_low | output | 17 | Request to drive the line low |
| key_state | output | 17 | Per-slot key detection, indexed by slot |
| cur_slot | output | 5 | Current slot number |
| cycle_done | output | 1 | Final strobe of a full ring |

## Verification
`drv_low`, `scan_own` and `cycle_done` are decoded combinationally from the slot and strobe counters. They therefore move on the clock edge that follows a strobe, and `scan_own` follows `scan_en` within the same cycle. Inputs are changed at the falling edge and all samples are taken 1 time unit later. With the strobe held high, sample index n therefore sees the state after n rising edges. That makes the pulse length, the first index of the next slot and the `cycle_done` index exact numbers: W, W x F and 17 x W x F - 1.

`key_state` is a register, so it is read only after the ring that loaded it has finished. The disable and restart checks are taken one edge after `scan_en` falls.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

    typedef struct packed {
        logic [1:0] wcode;
        logic [1:0] gcode;
    } kscan_cfg_t;

    typedef enum logic {
        PH_PULSE = 1'b0,
        PH_GAP   = 1'b1
    } kscan_phase_t;

    // Pulse length in strobes: base doubled per code step.
    function automatic int unsigned pulse_len(int unsigned base, logic [1:0] wcode);
        return base << wcode;
    endfunction

    // Slot length in pulse widths; the reserved code falls back to the widest.
    function automatic int unsigned slot_factor(logic [1:0] gcode);
        case (gcode)
            2'd0:    return 2;
            2'd1:    return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/kscan_timer.sv
module kscan_timer
    import kscan_pkg::*;
#(
    parameter int NSLOTS = 17,
    parameter int BASE   = 4,
    parameter int CNT_W  = 8,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  kscan_cfg_t        cfg,
    output logic [SLOT_W-1:0] slot,
    output kscan_phase_t      phase,
    output logic              sample_now,
    output logic              cycle_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] plen;
    logic [CNT_W-1:0] slen;
    logic             slot_end;
    logic             last_slot;

    assign plen      = CNT_W'(pulse_len(BASE, cfg.wcode));
    assign slen      = CNT_W'(pulse_len(BASE, cfg.wcode) * slot_factor(cfg.gcode));
    assign last_slot = (slot == SLOT_W'(NSLOTS - 1));
    assign slot_end  = run && tick && (cnt >= slen - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            slot <= '0;
        end else if (tick) begin
            if (cnt >= slen - CNT_W'(1)) begin
                cnt  <= '0;
                slot <= last_slot ? '0 : slot + SLOT_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign phase      = (cnt < plen) ? PH_PULSE : PH_GAP;
    assign sample_now = run && tick && (cnt == plen - CNT_W'(1));
    assign cycle_end  = slot_end && last_slot;

endmodule

// File: rtl/kscan_drive.sv
module kscan_drive
    import kscan_pkg::*;
#(
    parameter int NLINES = 17,
    parameter int SLOT_W = 5
) (
    input  logic              run,
    input  logic [SLOT_W-1:0] slot,
    input  kscan_phase_t      phase,
    input  logic [NLINES-1:0] line_sel,
    input  logic [NLINES-1:0] in_only,
    output logic [NLINES-1:0] scan_own,
    output logic [NLINES-1:0] drv_low
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        // Descending order: the highest line owns slot 0.
        localparam int OWN_SLOT = NLINES - 1 - i;
        logic mine;
        assign mine        = (slot == SLOT_W'(OWN_SLOT));
        assign scan_own[i] = run && line_sel[i];
        assign drv_low[i]  = run && line_sel[i] && !in_only[i] && mine && (phase == PH_PULSE);
    end

endmodule

// File: rtl/kscan_sample.sv
module kscan_sample #(
    parameter int NLINES = 17,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_now,
    input  logic [SLOT_W-1:0] slot,
    input  logic [NLINES-1:0] line_sel,
    input  logic [NLINES-1:0] in_only,
    input  logic [NLINES-1:0] ret_in,
    output logic [NLINES-1:0] key_state
);
    logic [NLINES-1:0] slot_hit;

    for (genvar s = 0; s < NLINES; s++) begin : g_slot
        localparam int LINE = NLINES - 1 - s;
        logic [NLINES-1:0] others;
        logic              can_drive;
        always_comb begin
            others       = line_sel;
            others[LINE] = 1'b0;
        end
        assign can_drive   = line_sel[LINE] && !in_only[LINE];
        assign slot_hit[s] = can_drive && (|(~ret_in & others));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_state <= '0;
        end else if (sample_now) begin
            for (int s = 0; s < NLINES; s++) begin
                if (slot == SLOT_W'(s)) key_state[s] <= slot_hit[s];
            end
        end
    end

endmodule

// File: rtl/kscan_seq.sv
module kscan_seq
    import kscan_pkg::*;
#(
    parameter int NLINES     = 17,
    parameter int PULSE_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              scan_en,
    input  logic [16:0]       line_sel,
    input  logic [16:0]       in_only,
    input  logic [1:0]        width_code,
    input  logic [1:0]        gap_code,
    input  logic [16:0]       ret_in,
    output logic [16:0]       scan_own,
    output logic [16:0]       drv_low,
    output logic [16:0]       key_state,
    output logic [4:0]        cur_slot,
    output logic              cycle_done
);
    localparam int MAX_SLOT = PULSE_BASE * 8 * 4;
    localparam int CNT_W    = $clog2(MAX_SLOT + 1);
    localparam int SLOT_W   = $clog2(NLINES);

    kscan_cfg_t   cfg;
    kscan_phase_t phase;
    logic         sample_now;

    assign cfg.wcode = width_code;
    assign cfg.gcode = gap_code;

    kscan_timer #(
        .NSLOTS(NLINES), .BASE(PULSE_BASE), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) i_timer (
        .clk(clk), .rst(rst), .run(scan_en), .tick(tick), .cfg(cfg),
        .slot(cur_slot), .phase(phase), .sample_now(sample_now), .cycle_end(cycle_done)
    );

    kscan_drive #(.NLINES(NLINES), .SLOT_W(SLOT_W)) i_drive (
        .run(scan_en), .slot(cur_slot), .phase(phase),
        .line_sel(line_sel), .in_only(in_only),
        .scan_own(scan_own), .drv_low(drv_low)
    );

    kscan_sample #(.NLINES(NLINES), .SLOT_W(SLOT_W)) i_sample (
        .clk(clk), .rst(rst), .sample_now(sample_now), .slot(cur_slot),
        .line_sel(line_sel), .in_only(in_only), .ret_in(ret_in),
        .key_state(key_state)
    );

endmodule

// File: rtl/kscan_seq_chk.sv
module kscan_seq_chk #(
    parameter int NLINES = 17,
    parameter int SLOT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              scan_en,
    input logic [NLINES-1:0] line_sel,
    input logic [NLINES-1:0] in_only,
    input logic [NLINES-1:0] scan_own,
    input logic [NLINES-1:0] drv_low,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              cycle_done
);
    a_r6_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_low));

    a_r6_only_capable: assert property (@(posedge clk) disable iff (rst)
        (drv_low & ~(line_sel & ~in_only)) == '0);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !scan_en |-> (scan_own == '0 && drv_low == '0));

    a_r3_slot_step: assert property (@(posedge clk) disable iff (rst)
        ($past(scan_en) && $past(tick) && cur_slot != $past(cur_slot))
        |-> (cur_slot == $past(cur_slot) + SLOT_W'(1) || cur_slot == '0));

    a_r8_ring_wrap: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> cur_slot == '0);

    a_r10_held_start: assert property (@(posedge clk) disable iff (rst)
        !$past(scan_en) |-> cur_slot == '0);

    a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(scan_en) && !$past(tick)) |-> $stable(cur_slot));

endmodule

bind kscan_seq kscan_seq_chk #(.NLINES(NLINES), .SLOT_W(SLOT_W)) i_chk (
    .clk(clk), .rst(rst), .tick(tick), .scan_en(scan_en),
    .line_sel(line_sel), .in_only(in_only), .scan_own(scan_own),
    .drv_low(drv_low), .cur_slot(cur_slot), .cycle_done(cycle_done)
);

// File: tb/test_kscan_seq.sv
module test_kscan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N = 17;

    typedef struct packed {
        logic [1:0] w;
        logic [1:0] g;
        logic [7:0] pw;
        logic [7:0] sl;
    } vec_t;

    // width code, gap code, expected pulse strobes, expected slot strobes
    localparam vec_t VECS [5] = '{
        '{w: 2'd0, g: 2'd0, pw: 8'd4,  sl: 8'd8},
        '{w: 2'd1, g: 2'd1, pw: 8'd8,  sl: 8'd24},
        '{w: 2'd2, g: 2'd2, pw: 8'd16, sl: 8'd64},
        '{w: 2'd3, g: 2'd0, pw: 8'd32, sl: 8'd64},
        '{w: 2'd0, g: 2'd3, pw: 8'd4,  sl: 8'd16}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic scan_en = 1'b0;
    logic [N-1:0] line_sel = '0;
    logic [N-1:0] in_only = '0;
    logic [1:0] width_code = 2'd0;
    logic [1:0] gap_code = 2'd0;
    logic [N-1:0] ret_in;
    logic [N-1:0] scan_own, drv_low, key_state;
    logic [4:0] cur_slot;
    logic cycle_done;
    logic key_on = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Key model: a key joins line 10 and line 3.
    always_comb begin
        ret_in = '1;
        if (key_on) begin
            ret_in[3]  = ~drv_low[10];
            ret_in[10] = ~drv_low[3];
        end
    end

    kscan_seq i_kscan_seq (
        .clk(clk), .rst(rst), .tick(tick), .scan_en(scan_en),
        .line_sel(line_sel), .in_only(in_only), .width_code(width_code),
        .gap_code(gap_code), .ret_in(ret_in), .scan_own(scan_own),
        .drv_low(drv_low), .key_state(key_state), .cur_slot(cur_slot),
        .cycle_done(cycle_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Enable at a falling edge and walk one full ring, recording timings.
    task automatic run_ring(output int pw, output int sl, output int cyc,
                            output int order_err, output int l15, output int l14,
                            output int first13);
        int prev;
        pw = 0; sl = -1; cyc = -1; order_err = 0; l15 = 0; l14 = 0; first13 = -1;
        prev = N;
        @(negedge clk);
        scan_en = 1'b1;
        #1;
        for (int idx = 0; idx < 17 * 128 + 20; idx++) begin
            if ($countones(drv_low) > 1) order_err++;
            for (int b = 0; b < N; b++) begin
                if (drv_low[b] && b != prev) begin
                    if (b >= prev) order_err++;
                    prev = b;
                end
            end
            if (drv_low[16]) pw++;
            if (drv_low[15] && sl < 0) sl = idx;
            if (drv_low[15]) l15++;
            if (drv_low[14]) l14++;
            if (drv_low[13] && first13 < 0) first13 = idx;
            if (cycle_done) begin
                cyc = idx;
                break;
            end
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pw, sl, cyc, oe, l15, l14, f13;
        int bad;
        logic [4:0] hold_slot;
        logic [N-1:0] hold_drv;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(key_state == '0, "R1 key_state", int'(key_state), 0);
        chk(drv_low == '0 && scan_own == '0, "R1 drive", int'(drv_low), 0);
        chk(cur_slot == '0 && !cycle_done, "R1 slot", int'(cur_slot), 0);

        // R2 global disable ignores the masks
        line_sel = '1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (scan_own != '0 || drv_low != '0 || cur_slot != '0) bad++;
        end
        chk(bad == 0, "R2 disabled quiet", bad, 0);

        // Table walk: R4 pulse, R5 slot length, R8 ring length, R3 order
        foreach (VECS[v]) begin
            scan_en = 1'b0;
            width_code = VECS[v].w;
            gap_code = VECS[v].g;
            line_sel = '1;
            in_only = '0;
            step();
            run_ring(pw, sl, cyc, oe, l15, l14, f13);
            chk(pw == int'(VECS[v].pw), "R4 pulse width", pw, int'(VECS[v].pw));
            chk(sl == int'(VECS[v].sl), "R5 slot length", sl, int'(VECS[v].sl));
            chk(cyc == 17 * int'(VECS[v].sl) - 1, "R8 ring length", cyc, 17 * int'(VECS[v].sl) - 1);
            if (v == 0) begin
                chk(oe == 0, "R3 descending order", oe, 0);
                chk(scan_own == line_sel, "R2 ownership", int'(scan_own), int'(line_sel));
            end
            @(negedge clk);
            scan_en = 1'b0;
        end

        // R7 dummy slots: line 14 deselected, line 15 input-only
        width_code = 2'd0;
        gap_code = 2'd0;
        line_sel = '1;
        line_sel[14] = 1'b0;
        in_only = '0;
        in_only[15] = 1'b1;
        step();
        run_ring(pw, sl, cyc, oe, l15, l14, f13);
        chk(l15 == 0, "R7 input-only silent", l15, 0);
        chk(l14 == 0, "R7 deselected silent", l14, 0);
        chk(f13 == 24, "R7 dummy slot length", f13, 24);
        chk(oe == 0, "R6 single driver", oe, 0);
        @(negedge clk);
        scan_en = 1'b0;

        // R9 key sampling: key between lines 10 and 3 -> slots 6 and 13
        line_sel = '1;
        in_only = '0;
        key_on = 1'b1;
        step();
        run_ring(pw, sl, cyc, oe, l15, l14, f13);
        step();
        chk(key_state == ((17'd1 << 6) | (17'd1 << 13)), "R9 key detected",
            int'(key_state), int'((17'd1 << 6) | (17'd1 << 13)));
        key_on = 1'b0;
        for (int i = 0; i < 17 * 8; i++) step();
        chk(key_state == '0, "R9 key released", int'(key_state), 0);

        // R11 hold while strobe is low (mid slot 1)
        @(negedge clk);
        scan_en = 1'b0;
        step();
        scan_en = 1'b1;
        for (int i = 0; i < 9; i++) step();
        tick = 1'b0;
        #1;
        hold_slot = cur_slot;
        hold_drv = drv_low;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (cur_slot != hold_slot || drv_low != hold_drv) bad++;
        end
        chk(bad == 0 && hold_slot == 5'd1, "R11 hold", int'(hold_slot), 1);

        // R10 restart from slot 0 after disable
        tick = 1'b1;
        for (int i = 0; i < 20; i++) step();
        scan_en = 1'b0;
        step();
        chk(cur_slot == '0 && drv_low == '0, "R10 cleared", int'(cur_slot), 0);
        scan_en = 1'b1;
        #1;
        chk(drv_low == (17'd1 << 16), "R10 restart slot", int'(drv_low), int'(17'd1 << 16));

        // R1 reset clears a loaded key state
        scan_en = 1'b0;
        key_on = 1'b1;
        step();
        run_ring(pw, sl, cyc, oe, l15, l14, f13);
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(key_state == '0 && cur_slot == '0, "R1 reset clears", int'(key_state), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule